// File: doc/BRIEF.md
# Multiplexed Parallel I/O Controller

This block manages 32 bidirectional I/O lines. Each line can be handed either to the controller itself or to an on-chip peripheral that shares the pad. While the controller owns a line, it chooses the line's direction and output level. While the peripheral owns it, the peripheral's own output and output enable reach the pad. The block always reports the sensed pad level. It can also pass that level through a short glitch filter, and it raises one interrupt when a watched line changes.

Software controls the block through a simple word-addressed read/write port. Ownership, output enable, output level, filter enable and interrupt enable are each held in one 32-bit register. Each of these registers has a write-one-to-set address, a write-one-to-clear address and a read-only status address. Six lines have no peripheral behind them. They stay with the controller no matter what is written.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: Address map (5-bit word address, bits [4:2] pick the function, bits [1:0] pick the action):
  - Functions: 0 ownership, 1 output enable, 2 output level, 3 filter enable, 4 interrupt enable.
  - Actions: 0 set, 1 clear, 2 status.
  - A write to a set address forces the written 1 bits to 1. A write to a clear address forces them to 0. Zero bits leave their bit unchanged.
  - A read presented with `bus_rd` appears on `bus_rdata` after the next clock edge, and the value returned is the one held before that edge.
- R2: After reset, every line is owned by the controller except those in the parameter mask `PER_AT_RESET` (default 0x0000000F). Output enable, output level, filter enable, interrupt enable and change status all reset to 0.
- R3: Lines 16, 17, 18, 19, 23 and 24 (mask 0x018F0000) ignore ownership set and clear writes, and their ownership status bits always read 1.
- R4: `per_in` is 0 on every line the controller owns. On every other line, `per_in` equals the sensed line level.
- R5: On a controller-owned line, `pad_oe` follows the output-enable bit and `pad_out` follows the output-level bit. On a peripheral-owned line, they follow `per_oe` and `per_out`.
- R6: Address 20 reads the sensed level of all lines whatever their owner. A pad change sampled at edge k shows in that level after edge k+2 when the line is unfiltered.
- R7: On a line with its filter enabled, a new level is accepted only once two consecutive synchronized samples agree, which adds one cycle of delay. A one-cycle pulse never reaches the sensed level. The filter acts the same on peripheral-owned and controller-owned lines.
- R8: Every change of a sensed line level sets that line's bit in the change status at address 21. Reading address 21 returns the bits and clears them, but a change in that same cycle is kept.
- R9: `irq` is high exactly while some change-status bit is 1 with its interrupt-enable bit also 1.
- R10: Writes to status addresses, to address 20, to address 21 and to unmapped addresses change no register. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Sensed pad levels (asynchronous) |
| pad_out | output | 32 | Pad output level |
| pad_oe | output | 32 | Pad output enable |
| per_out | input | 32 | Peripheral output levels |
| per_oe | input | 32 | Peripheral output enables |
| per_in | output | 32 | Gated input to the peripheral |
| irq | output | 1 | Change interrupt |

## Verification
Pad muxing and `irq` are combinational from registers, so they are due right after the edge that wrote the register. Register reads are due one edge after the strobe. An unfiltered pad change is due in the sensed level two edges after it is sampled, and a filtered change is due three edges after. The change status and `irq` move on the same edge as the sensed level.

The bench model keeps a queue of sampled pad words and reproduces these delays from it. Inputs are driven just after the falling edge and outputs are compared on the next falling edge, so each result is checked in the cycle it is due. Directed checks wait well past the longest delay before reading.

// File: rtl/gpio_mux_pkg.sv
// Shared constants for the multiplexed parallel I/O controller.
// Assumes a 5-bit word address: bits [4:2] select a function, bits [1:0] an action.
package gpio_mux_pkg;
    localparam int AW    = 5;
    localparam int NFUNC = 5;  // ownership, output enable, level, filter, irq enable

    typedef enum logic [1:0] {
        OP_SET  = 2'd0,
        OP_CLR  = 2'd1,
        OP_STAT = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    localparam logic [AW-1:0] ADDR_PIN = 5'd20;
    localparam logic [AW-1:0] ADDR_CHG = 5'd21;
endpackage

// File: rtl/gpio_setclr_reg.sv
// One write-one-to-set / write-one-to-clear register.
// Bits in FORCE1 always read 1 and ignore writes. Assumes set and clear strobes are never both high.
module gpio_setclr_reg #(
    parameter int           W       = 32,
    parameter logic [W-1:0] RST_VAL = '0,
    parameter logic [W-1:0] FORCE1  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Apply set or clear masks; forced bits are re-asserted on every update.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= RST_VAL | FORCE1;
        else if (set_stb) q <= q | wdata | FORCE1;
        else if (clr_stb) q <= (q & ~wdata) | FORCE1;
    end

    a_r1_set: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((q & $past(wdata)) == $past(wdata)));
    a_r1_clr: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((q & $past(wdata) & ~FORCE1) == '0));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(q));
endmodule

// File: rtl/gpio_in_filter.sv
// Input path: two-flop synchronizer, then per-line optional two-sample glitch filter.
// Produces the sensed level and a one-cycle change flag per line. Assumes pad_in is asynchronous.
module gpio_in_filter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    input  logic [W-1:0] flt_en,
    output logic [W-1:0] level,
    output logic [W-1:0] chg_evt
);
    logic [W-1:0] sync1, sync2, prev;
    logic [W-1:0] lvl_nx;

    // Synchronize the pads and keep one older sample for the filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= '0;
            sync2 <= '0;
            prev  <= '0;
        end else begin
            sync1 <= pad_in;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    // Per line: filtered lines take a level only when two samples agree.
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_line
            always_comb begin
                if (flt_en[i]) lvl_nx[i] = (sync2[i] == prev[i]) ? sync2[i] : level[i];
                else           lvl_nx[i] = sync2[i];
            end
        end
    endgenerate

    // Register the sensed level.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= lvl_nx;
    end

    assign chg_evt = lvl_nx ^ level;

    a_r7_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((level ^ $past(level)) & $past(flt_en & (sync2 ^ prev))) == '0);
endmodule

// File: rtl/gpio_chg_irq.sv
// Change-status collector and interrupt. Read-clear keeps changes that arrive in the same cycle.
module gpio_chg_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt,
    input  logic         rd_clr,
    input  logic [W-1:0] ien,
    output logic [W-1:0] chg,
    output logic         irq
);
    // Accumulate changes; a read of the status wipes older ones.
    always_ff @(posedge clk) begin
        if (!rst_n) chg <= '0;
        else        chg <= (rd_clr ? '0 : chg) | evt;
    end

    // Interrupt when any enabled line has a recorded change.
    always_comb irq = |(chg & ien);

    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> (chg == $past(evt)));
endmodule

// File: rtl/gpio_pin_mux.sv
// Per-line ownership mux: pad drive and peripheral input gating. Purely combinational.
module gpio_pin_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0] own,
    input  logic [W-1:0] oe,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] per_out,
    input  logic [W-1:0] per_oe,
    input  logic [W-1:0] level,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] per_in
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            // Select the pad source and gate the peripheral input by owner.
            always_comb begin
                pad_out[i] = own[i] ? lvl[i] : per_out[i];
                pad_oe[i]  = own[i] ? oe[i]  : per_oe[i];
                per_in[i]  = own[i] ? 1'b0   : level[i];
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_mux_ctrl.sv
// Top of the multiplexed parallel I/O controller: address decode, five set/clear
// registers, input path, change interrupt and pin mux. Assumes one access per cycle.
module gpio_mux_ctrl #(
    parameter int              NPIN         = 32,
    parameter logic [NPIN-1:0] GP_ONLY      = 32'h018F_0000,
    parameter logic [NPIN-1:0] PER_AT_RESET = 32'h0000_000F
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic                         bus_rd,
    input  logic [gpio_mux_pkg::AW-1:0]  bus_addr,
    input  logic [NPIN-1:0]              bus_wdata,
    output logic [NPIN-1:0]              bus_rdata,
    input  logic [NPIN-1:0]              pad_in,
    output logic [NPIN-1:0]              pad_out,
    output logic [NPIN-1:0]              pad_oe,
    input  logic [NPIN-1:0]              per_out,
    input  logic [NPIN-1:0]              per_oe,
    output logic [NPIN-1:0]              per_in,
    output logic                         irq
);
    import gpio_mux_pkg::*;

    localparam int FW = AW - 2;

    logic [NFUNC-1:0] set_stb, clr_stb;
    logic [NPIN-1:0]  regq [NFUNC];
    logic [NPIN-1:0]  level, chg_evt, chg;
    logic [NPIN-1:0]  rd_mux;
    logic             chg_rd;

    genvar f;
    generate
        for (f = 0; f < NFUNC; f++) begin : g_func
            localparam logic [FW-1:0]   FSEL = FW'(f);
            localparam logic [NPIN-1:0] RV   = (f == 0) ? ((~PER_AT_RESET) | GP_ONLY) : '0;
            localparam logic [NPIN-1:0] FM   = (f == 0) ? GP_ONLY : '0;

            assign set_stb[f] = bus_wr && (bus_addr == {FSEL, OP_SET});
            assign clr_stb[f] = bus_wr && (bus_addr == {FSEL, OP_CLR});

            gpio_setclr_reg #(.W(NPIN), .RST_VAL(RV), .FORCE1(FM)) u_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_stb (set_stb[f]),
                .clr_stb (clr_stb[f]),
                .wdata   (bus_wdata),
                .q       (regq[f])
            );
        end
    endgenerate

    gpio_in_filter #(.W(NPIN)) u_in (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_in  (pad_in),
        .flt_en  (regq[3]),
        .level   (level),
        .chg_evt (chg_evt)
    );

    assign chg_rd = bus_rd && (bus_addr == ADDR_CHG);

    gpio_chg_irq #(.W(NPIN)) u_chg (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (chg_evt),
        .rd_clr (chg_rd),
        .ien    (regq[4]),
        .chg    (chg),
        .irq    (irq)
    );

    gpio_pin_mux #(.W(NPIN)) u_mux (
        .own     (regq[0]),
        .oe      (regq[1]),
        .lvl     (regq[2]),
        .per_out (per_out),
        .per_oe  (per_oe),
        .level   (level),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .per_in  (per_in)
    );

    // Select the readable word for the current address; unmapped reads give 0.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NFUNC; k++) begin
            if (bus_addr == {FW'(k), OP_STAT}) rd_mux = regq[k];
        end
        if (bus_addr == ADDR_PIN) rd_mux = level;
        if (bus_addr == ADDR_CHG) rd_mux = chg;
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: tb/gpio_mux_ctrl_tb_top.sv
`timescale 1ns/100ps
module gpio_mux_ctrl_tb_top;
    localparam logic [31:0] GP  = 32'h018F_0000;
    localparam logic [31:0] PRR = 32'h0000_000F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe;
    logic [31:0] per_out = '0, per_oe = '0, per_in;
    logic        irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_mux_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .per_out(per_out), .per_oe(per_oe), .per_in(per_in), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: register words and a queue of pad samples.
    bit [31:0] m_own, m_oe, m_lvl, m_flt, m_ien, m_lev, m_chg, m_rdata;
    bit [31:0] hist[$];
    bit [4:0]  m_last_addr;

    function automatic bit [31:0] m_read(input bit [4:0] a);
        case (a)
            5'd2:  return m_own;
            5'd6:  return m_oe;
            5'd10: return m_lvl;
            5'd14: return m_flt;
            5'd18: return m_ien;
            5'd20: return m_lev;
            5'd21: return m_chg;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = ~PRR | GP; m_oe = 0; m_lvl = 0; m_flt = 0; m_ien = 0;
            m_lev = 0; m_chg = 0; m_rdata = 0; m_last_addr = 0;
            hist = '{32'h0, 32'h0, 32'h0, 32'h0};
        end else begin
            bit [31:0] nlev;
            bit        clr;
            hist.push_front(pad_in);
            void'(hist.pop_back());
            for (int b = 0; b < 32; b++) begin
                if (!m_flt[b])                 nlev[b] = hist[2][b];
                else if (hist[2][b] == hist[3][b]) nlev[b] = hist[2][b];
                else                           nlev[b] = m_lev[b];
            end
            clr = 0;
            if (bus_rd) begin
                m_rdata = m_read(bus_addr);
                m_last_addr = bus_addr;
                clr = (bus_addr == 5'd21);
            end
            m_chg = (clr ? 32'h0 : m_chg) | (nlev ^ m_lev);
            m_lev = nlev;
            if (bus_wr) begin
                case (bus_addr)
                    5'd0:  m_own = m_own | bus_wdata;
                    5'd1:  m_own = (m_own & ~bus_wdata) | GP;
                    5'd4:  m_oe  = m_oe | bus_wdata;
                    5'd5:  m_oe  = m_oe & ~bus_wdata;
                    5'd8:  m_lvl = m_lvl | bus_wdata;
                    5'd9:  m_lvl = m_lvl & ~bus_wdata;
                    5'd12: m_flt = m_flt | bus_wdata;
                    5'd13: m_flt = m_flt & ~bus_wdata;
                    5'd16: m_ien = m_ien | bus_wdata;
                    5'd17: m_ien = m_ien & ~bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 pad_out", pad_out, (m_own & m_lvl) | (~m_own & per_out));
            chk("R5 pad_oe",  pad_oe,  (m_own & m_oe)  | (~m_own & per_oe));
            chk("R4 per_in",  per_in,  ~m_own & m_lev);
            chk("R9 irq",     {31'h0, irq}, {31'h0, |(m_chg & m_ien)});
            case (m_last_addr)
                5'd2:    chk("R3 rdata", bus_rdata, m_rdata);
                5'd20:   chk("R6 rdata", bus_rdata, m_rdata);
                5'd21:   chk("R8 rdata", bus_rdata, m_rdata);
                default: chk("R1 rdata", bus_rdata, m_rdata);
            endcase
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); #1;
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        #1 bus_rd = 0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        #1 rst_n = 1;

        // R2 reset values
        rd_chk("R2 own", 5'd2, 32'hFFFF_FFF0);
        rd_chk("R2 oe", 5'd6, 32'h0);
        rd_chk("R2 lvl", 5'd10, 32'h0);
        rd_chk("R2 flt", 5'd14, 32'h0);
        rd_chk("R2 ien", 5'd18, 32'h0);
        rd_chk("R2 chg", 5'd21, 32'h0);

        // R3 fixed general-purpose lines, R1 set/clear
        wr(5'd1, 32'hFFFF_FFFF);
        rd_chk("R3 own after clear", 5'd2, 32'h018F_0000);
        wr(5'd0, 32'h0000_00F0);
        rd_chk("R1 own after set", 5'd2, 32'h018F_00F0);

        // R10 writes to read-only and unmapped addresses
        wr(5'd6, 32'hFFFF_FFFF);
        wr(5'd3, 32'hFFFF_FFFF);
        wr(5'd22, 32'hFFFF_FFFF);
        wr(5'd20, 32'hFFFF_FFFF);
        rd_chk("R10 oe untouched", 5'd6, 32'h0);
        rd_chk("R10 lvl untouched", 5'd10, 32'h0);
        rd_chk("R10 unmapped read", 5'd23, 32'h0);

        // R5 pad muxing by owner
        wr(5'd4, 32'h0000_00F0);
        wr(5'd8, 32'h0000_0050);
        @(negedge clk); #1;
        per_oe = 32'h0000_000F; per_out = 32'h0000_000A;
        @(negedge clk);
        chk("R5 oe low byte", {24'h0, pad_oe[7:0]}, 32'h0000_00FF);
        chk("R5 out low byte", {24'h0, pad_out[7:0]}, 32'h0000_005A);

        // R4 and R6: gated peripheral input, sensed level, R8 change status
        #1 pad_in = 32'h0000_0033;
        idle(6);
        chk("R4 per_in low byte", {24'h0, per_in[7:0]}, 32'h0000_0003);
        rd_chk("R6 pin level", 5'd20, 32'h0000_0033);
        rd_chk("R8 chg read", 5'd21, 32'h0000_0033);
        rd_chk("R8 chg cleared", 5'd21, 32'h0);

        // R7 filter rejects a one-cycle pulse on line 0; line 1 unfiltered
        wr(5'd12, 32'h0000_0001);
        @(negedge clk); #1 pad_in = 32'h0000_0030;
        @(negedge clk); #1 pad_in = 32'h0000_0033;
        idle(6);
        rd_chk("R7 pulse rejected", 5'd20, 32'h0000_0033);
        rd_chk("R7 unfiltered pulse seen", 5'd21, 32'h0000_0002);
        @(negedge clk); #1 pad_in = 32'h0000_0032;
        repeat (3) @(negedge clk);
        #1 pad_in = 32'h0000_0033;
        idle(6);
        rd_chk("R7 long pulse passes", 5'd21, 32'h0000_0001);

        // R9 interrupt by mask
        wr(5'd16, 32'h0000_0004);
        @(negedge clk); #1 pad_in = 32'h0000_0037;
        idle(6);
        chk("R9 irq set", {31'h0, irq}, 32'h1);
        rd(5'd21, d);
        @(negedge clk);
        chk("R9 irq cleared", {31'h0, irq}, 32'h0);
        #1 pad_in = 32'h0000_003F;
        idle(6);
        chk("R9 masked line no irq", {31'h0, irq}, 32'h0);

        // Mixed random traffic checked against the model
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk); #1;
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_rd = !bus_wr && ($urandom_range(0, 2) == 0);
            bus_addr = 5'($urandom_range(0, 23));
            bus_wdata = $urandom & $urandom;
            if ($urandom_range(0, 3) == 0) pad_in = pad_in ^ ($urandom & $urandom & $urandom);
            if ($urandom_range(0, 7) == 0) begin
                per_out = $urandom;
                per_oe  = $urandom;
            end
        end
        @(negedge clk); #1;
        bus_wr = 0; bus_rd = 0;
        idle(4);
        finish_run();
    end
endmodule